// File: doc/BRIEF.md
# Nine-bit multiprocessor UART controller

A full-duplex asynchronous serial port run by one control/status byte and one data byte. A single mode bit selects the frame: eight data bits, or eight data bits plus a ninth bit. In nine-bit mode the ninth bit on transmit comes from a control bit. On receive, the ninth bit, or the stop bit in eight-bit mode, is captured into a status bit. Frames go out LSB first: a low start bit, the data bits, then one high stop bit. The line idles high.

A multiprocessor gate supports address filtering on a shared bus. While it is on, the receive-complete flag is raised, and the receive buffer loaded, only for frames whose ninth bit is 1 (nine-bit mode) or whose stop bit is 1 (eight-bit mode). The transmit-done and receive-complete flags stay set until software writes them to 0. The single interrupt output is high while either flag is set. Bit timing comes from an external tick at 16 times the bit rate.

Register access: `reg_sel`=0 addresses the control byte and `reg_sel`=1 the data byte. A data write sends a frame, and a data read returns the receive buffer.

Top module: `uart9_ctrl`

## Requirements
- R1: After reset the control byte reads 0x40, the receive buffer reads 0x00, `txd` is 1 and `irq` is 0.
- R2: Control bit positions, from bit 7 down to bit 0, are: frame mode (1 = nine-bit), a fixed 1, multiprocessor gate, receive enable, transmit ninth bit, received ninth/stop bit, transmit-done flag, receive-complete flag. Bit 6 always reads 1 and ignores writes. The other bits read back what was written.
- R3: A data write while the transmitter is idle sends a frame of 16 ticks per bit: start 0, data LSB first, stop 1. In eight-bit mode the frame is 10 bits and the transmit ninth bit has no effect.
- R4: In nine-bit mode the frame is 11 bits. The transmit ninth bit, as it stood at the data write, is sent between the last data bit and the stop bit.
- R5: The transmit-done flag is set at the clock edge on which the stop bit begins. A data write while a frame is being sent is ignored.
- R6: With receive enable on, a valid eight-bit frame loads the buffer with its byte, loads the received ninth/stop bit with the stop bit, and sets the receive-complete flag.
- R7: In nine-bit mode the received ninth/stop bit is loaded with the ninth data bit of every received frame, including frames the gate rejects.
- R8: With the gate on, a frame whose ninth bit (nine-bit mode) or stop bit (eight-bit mode) is 0 leaves the receive-complete flag and the buffer unchanged. With the gate off, such frames are accepted.
- R9: With receive enable off, no frame is received: the receive-complete flag stays 0 and the buffer is unchanged.
- R10: A low pulse on `rxd` that is high again at the middle of the start bit is discarded as a false start. The receiver then accepts the next valid frame.
- R11: `irq` equals the OR of the two flags. Each flag stays set until software writes 0 to it. A hardware set in the same cycle as a software clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| irq | output | 1 | Interrupt, high while either flag is set |

## Verification
A wrong bit index or tick count in the transmitter shows on `txd` within one bit time, 16 ticks. The transmit-done flag appearing one bit early or late exposes a wrong stop index in the same frame. A receiver whose sample point or bit counter has drifted shows up at the end of the frame as a wrong buffer byte, a wrong received ninth/stop bit, or a flag that the gate should have held back. A stuck receiver state shows as the next valid frame never raising `irq`.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    localparam int unsigned BYTE_W = 8;

    // control byte bit positions
    localparam int CB_MODE = 7;
    localparam int CB_ONE  = 6;
    localparam int CB_MCE  = 5;
    localparam int CB_REN  = 4;
    localparam int CB_TB8  = 3;
    localparam int CB_RB8  = 2;
    localparam int CB_TI   = 1;
    localparam int CB_RI   = 0;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              nine_mode,
    input  logic              ninth_bit,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              busy,
    output logic              ti_set
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int SUB_W   = $clog2(OS);
    localparam logic [IDX_W-1:0] STOP_SHORT = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] STOP_LONG  = IDX_W'(DATA_W + 2);
    localparam logic [SUB_W-1:0] SUB_LAST   = SUB_W'(OS - 1);

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   stop_idx;
        logic [SUB_W-1:0]   sub;
        logic [FRAME_W-1:0] frame;
    } tx_state_t;

    tx_state_t s_q, s_d;
    logic      set_d;

    always_comb begin
        s_d   = s_q;
        set_d = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy     = 1'b1;
                s_d.idx      = '0;
                s_d.sub      = '0;
                s_d.stop_idx = nine_mode ? STOP_LONG : STOP_SHORT;
                s_d.frame    = {1'b1, (nine_mode ? ninth_bit : 1'b1), data, 1'b0};
            end
        end else if (tick) begin
            if (s_q.sub == SUB_LAST) begin
                s_d.sub = '0;
                if (s_q.idx == s_q.stop_idx) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    set_d   = (s_d.idx == s_q.stop_idx);
                end
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign txd    = s_q.busy ? s_q.frame[s_q.idx] : 1'b1;
    assign busy   = s_q.busy;
    assign ti_set = set_d;

    // R5: the done pulse coincides with entering the stop bit
    a_r5_ti_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ti_set |=> (s_q.busy && txd && s_q.idx == s_q.stop_idx));

    // R5: a start request during a frame does not restart it
    a_r5_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start && !tick) |=> (s_q.busy && $stable(s_q.frame) && $stable(s_q.idx)));

    // R3: the stop bit drives the line high
    a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.idx == s_q.stop_idx) |-> txd);

    // R3: a new frame opens with a low start bit
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> !txd);

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              enable,
    input  logic              nine_mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              nine_bit
);

    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam int SUB_W = $clog2(OS);
    localparam logic [IDX_W-1:0] STOP_SHORT = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] STOP_LONG  = IDX_W'(DATA_W + 1);
    localparam logic [SUB_W-1:0] SUB_MID    = SUB_W'(OS / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_LAST   = SUB_W'(OS - 1);

    typedef struct packed {
        logic [1:0]       sync;
        rx_state_e        st;
        logic             mode;
        logic [IDX_W-1:0] idx;
        logic [SUB_W-1:0] sub;
        logic [DATA_W:0]  shreg;
    } rx_reg_t;

    rx_reg_t          s_q, s_d;
    logic             line;
    logic             done_c;
    logic             nine_c;
    logic [IDX_W-1:0] stop_idx;

    assign line     = s_q.sync[1];
    assign stop_idx = s_q.mode ? STOP_LONG : STOP_SHORT;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], rxd};
        done_c   = 1'b0;
        nine_c   = 1'b0;
        if (!enable) begin
            s_d.st = RX_IDLE;
        end else begin
            case (s_q.st)
                RX_IDLE: begin
                    if (tick && !line) begin
                        s_d.st   = RX_START;
                        s_d.sub  = '0;
                        s_d.mode = nine_mode;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (s_q.sub == SUB_MID) begin
                            if (line) begin
                                s_d.st = RX_IDLE;
                            end else begin
                                s_d.st  = RX_BITS;
                                s_d.sub = '0;
                                s_d.idx = '0;
                            end
                        end else begin
                            s_d.sub = s_q.sub + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        if (s_q.sub == SUB_LAST) begin
                            s_d.sub = '0;
                            if (s_q.idx == stop_idx) begin
                                done_c = 1'b1;
                                nine_c = s_q.mode ? s_q.shreg[DATA_W] : line;
                                s_d.st = RX_IDLE;
                            end else begin
                                s_d.shreg[s_q.idx] = line;
                                s_d.idx = s_q.idx + 1'b1;
                            end
                        end else begin
                            s_d.sub = s_q.sub + 1'b1;
                        end
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done     = done_c;
    assign data     = s_q.shreg[DATA_W-1:0];
    assign nine_bit = nine_c;

    // R9: with reception off the receiver is parked
    a_r9_off_parks: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (s_q.st == RX_IDLE));

    // R9: no completion while reception is off
    a_r9_no_done_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !done);

    // R10: high line at mid start bit abandons the frame
    a_r10_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && s_q.st == RX_START && tick && s_q.sub == SUB_MID && line) |=> (s_q.st == RX_IDLE));

endmodule

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
    import uart9_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              baud_tick,
    output logic              txd,
    input  logic              rxd,
    output logic              irq
);

    typedef struct packed {
        logic              mode;
        logic              mce;
        logic              ren;
        logic              tb8;
        logic              rb8;
        logic              ti;
        logic              ri;
        logic [BYTE_W-1:0] rbuf;
    } ctrl_t;

    ctrl_t             c_q, c_d;
    logic              tx_busy;
    logic              tx_ti_set;
    logic              rx_done;
    logic              rx_nine;
    logic [BYTE_W-1:0] rx_data;
    logic              ctrl_wr;

    assign ctrl_wr = wr_en && !reg_sel;

    uart9_tx #(.DATA_W(BYTE_W), .OS(OS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .start     (wr_en && reg_sel),
        .nine_mode (c_q.mode),
        .ninth_bit (c_q.tb8),
        .data      (wr_data),
        .txd       (txd),
        .busy      (tx_busy),
        .ti_set    (tx_ti_set)
    );

    uart9_rx #(.DATA_W(BYTE_W), .OS(OS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .rxd       (rxd),
        .enable    (c_q.ren),
        .nine_mode (c_q.mode),
        .done      (rx_done),
        .data      (rx_data),
        .nine_bit  (rx_nine)
    );

    always_comb begin
        c_d = c_q;
        if (ctrl_wr) begin
            c_d.mode = wr_data[CB_MODE];
            c_d.mce  = wr_data[CB_MCE];
            c_d.ren  = wr_data[CB_REN];
            c_d.tb8  = wr_data[CB_TB8];
            c_d.rb8  = wr_data[CB_RB8];
            c_d.ti   = wr_data[CB_TI];
            c_d.ri   = wr_data[CB_RI];
        end
        if (tx_ti_set) c_d.ti = 1'b1;
        if (rx_done) begin
            c_d.rb8 = rx_nine;
            if (!c_q.mce || rx_nine) begin
                c_d.ri   = 1'b1;
                c_d.rbuf = rx_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        if (reg_sel) begin
            rd_data = c_q.rbuf;
        end else begin
            rd_data          = '0;
            rd_data[CB_MODE] = c_q.mode;
            rd_data[CB_ONE]  = 1'b1;
            rd_data[CB_MCE]  = c_q.mce;
            rd_data[CB_REN]  = c_q.ren;
            rd_data[CB_TB8]  = c_q.tb8;
            rd_data[CB_RB8]  = c_q.rb8;
            rd_data[CB_TI]   = c_q.ti;
            rd_data[CB_RI]   = c_q.ri;
        end
    end

    assign irq = c_q.ti | c_q.ri;

    // R11: a transmit-done set survives a same-cycle software clear
    a_r11_ti_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ti_set |=> c_q.ti);

    // R11: the receive flag holds until software writes the control byte
    a_r11_ri_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ri && !ctrl_wr) |=> c_q.ri);

    // R8: an accepted frame raises the flag and fills the buffer
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && (!c_q.mce || rx_nine)) |=> (c_q.ri && c_q.rbuf == $past(rx_data)));

    // R8: a gated-out frame leaves the buffer alone
    a_r8_reject_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && c_q.mce && !rx_nine) |=> $stable(c_q.rbuf));

    // R8: a gated-out frame does not raise the flag
    a_r8_reject_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && c_q.mce && !rx_nine && !c_q.ri && !ctrl_wr) |=> !c_q.ri);

endmodule

// File: tb/uart9_ctrl_test.sv
`timescale 1ns/100ps
module uart9_ctrl_test;

    localparam int TDIV   = 4;
    localparam int BITCLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       baud_tick = 1'b0;
    logic       txd;
    logic       rxd = 1'b1;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int tcnt    = 0;
    logic mon_on = 1'b0;

    // behavioural transmit model
    int   m_ticks = -1;
    int   m_len   = 10;
    logic m_bits [0:10];
    logic m_mode = 1'b0;
    logic m_tb8  = 1'b0;
    logic m_ti   = 1'b0;
    logic m_idle_pre;
    logic m_set_now;

    uart9_ctrl #(.OS(16)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .baud_tick (baud_tick),
        .txd       (txd),
        .rxd       (rxd),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tcnt      = (tcnt + 1) % TDIV;
        baud_tick = (tcnt == 0);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ticks = -1;
            m_ti    = 1'b0;
            m_mode  = 1'b0;
            m_tb8   = 1'b0;
        end else begin
            m_idle_pre = (m_ticks < 0);
            m_set_now  = 1'b0;
            if (!m_idle_pre && baud_tick) begin
                m_ticks++;
                if (m_ticks == 16 * (m_len - 1)) m_set_now = 1'b1;
                if (m_ticks == 16 * m_len) m_ticks = -1;
            end
            if (wr_en && reg_sel && m_idle_pre) begin
                m_bits[0] = 1'b0;
                for (int i = 0; i < 8; i++) m_bits[i+1] = wr_data[i];
                if (m_mode) begin
                    m_bits[9]  = m_tb8;
                    m_bits[10] = 1'b1;
                    m_len      = 11;
                end else begin
                    m_bits[9]  = 1'b1;
                    m_bits[10] = 1'b1;
                    m_len      = 10;
                end
                m_ticks = 0;
            end
            if (wr_en && !reg_sel) begin
                m_mode = wr_data[7];
                m_tb8  = wr_data[3];
                m_ti   = wr_data[1];
            end
            if (m_set_now) m_ti = 1'b1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk("R3/R4 txd", {31'd0, txd}, {31'd0, (m_ticks < 0) ? 1'b1 : m_bits[m_ticks/16]});
            if (!reg_sel) chk("R5 ti flag", {31'd0, rd_data[1]}, {31'd0, m_ti});
        end
    end

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); #1;
        reg_sel = 1'b0; wr_data = v; wr_en = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); #1;
        reg_sel = 1'b1; wr_data = v; wr_en = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] v);
        @(negedge clk); #1;
        reg_sel = sel;
        #0.5;
        v = rd_data;
        reg_sel = 1'b0;
    endtask

    task automatic wait_tx_done();
        @(negedge clk);
        while (m_ticks >= 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic nine_en, input logic ninth, input logic stopb);
        @(negedge clk); #1;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (nine_en) send_bit(ninth);
        send_bit(stopb);
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, v); chk("R1 ctrl reset", {24'd0, v}, 32'h40);
        rd_reg(1'b1, v); chk("R1 rbuf reset", {24'd0, v}, 32'h00);
        chk("R1 txd idle", {31'd0, txd}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        mon_on = 1'b1;

        // R2 register layout, reserved bit
        wr_ctrl(8'h00); rd_reg(1'b0, v); chk("R2 bit6 ignores 0", {24'd0, v}, 32'h40);
        wr_ctrl(8'h3C); rd_reg(1'b0, v); chk("R2 readback", {24'd0, v}, 32'h7C);
        wr_ctrl(8'h00); rd_reg(1'b0, v); chk("R2 cleared", {24'd0, v}, 32'h40);

        // R3 eight-bit frame, TB8 set but unused; R5 write while busy ignored
        wr_ctrl(8'h08);
        wr_dat(8'hA5);
        repeat (100) @(negedge clk);
        wr_dat(8'h3C);
        wait_tx_done();
        rd_reg(1'b0, v); chk("R5 ti after frame", {24'd0, v}, 32'h4A);
        chk("R11 irq from ti", {31'd0, irq}, 32'd1);
        repeat (200) @(negedge clk);
        chk("R11 ti sticky", {31'd0, irq}, 32'd1);
        wr_ctrl(8'h88);
        chk("R11 irq after clear", {31'd0, irq}, 32'd0);

        // R4 nine-bit frames, ninth = TB8
        wr_dat(8'h5A);
        wait_tx_done();
        wr_ctrl(8'h80);
        wr_dat(8'hFF);
        wait_tx_done();
        rd_reg(1'b0, v); chk("R4 ti after nine-bit frame", {24'd0, v}, 32'hC2);
        wr_ctrl(8'h00);

        // R6 eight-bit reception
        wr_ctrl(8'h10);
        rx_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        rd_reg(1'b0, v); chk("R6 ctrl ri rb8", {24'd0, v}, 32'h55);
        rd_reg(1'b1, v); chk("R6 rbuf", {24'd0, v}, 32'hC3);
        chk("R11 irq from ri", {31'd0, irq}, 32'd1);
        wr_ctrl(8'h10);
        chk("R11 ri cleared", {31'd0, irq}, 32'd0);

        // R8 gate off: stop 0 accepted with rb8 = 0
        rx_frame(8'h11, 1'b0, 1'b0, 1'b0);
        rd_reg(1'b0, v); chk("R8 gate off stop0", {24'd0, v}, 32'h51);
        rd_reg(1'b1, v); chk("R8 gate off rbuf", {24'd0, v}, 32'h11);

        // R8 gate on, eight-bit: stop 0 rejected, stop 1 accepted
        wr_ctrl(8'h30);
        rx_frame(8'h22, 1'b0, 1'b0, 1'b0);
        rd_reg(1'b0, v); chk("R8 gate on stop0 ri", {24'd0, v}, 32'h70);
        rd_reg(1'b1, v); chk("R8 gate on stop0 rbuf", {24'd0, v}, 32'h11);
        rx_frame(8'h33, 1'b0, 1'b0, 1'b1);
        rd_reg(1'b0, v); chk("R8 gate on stop1", {24'd0, v}, 32'h75);
        rd_reg(1'b1, v); chk("R8 gate on stop1 rbuf", {24'd0, v}, 32'h33);

        // R7/R8 nine-bit with gate: ninth 0 rejected but rb8 loaded
        wr_ctrl(8'hB4);
        rx_frame(8'h42, 1'b1, 1'b0, 1'b1);
        rd_reg(1'b0, v); chk("R7 rb8 loaded on reject", {24'd0, v}, 32'hF0);
        rd_reg(1'b1, v); chk("R8 nine reject rbuf", {24'd0, v}, 32'h33);
        rx_frame(8'h77, 1'b1, 1'b1, 1'b1);
        rd_reg(1'b0, v); chk("R7 nine accept", {24'd0, v}, 32'hF5);
        rd_reg(1'b1, v); chk("R7 nine rbuf", {24'd0, v}, 32'h77);

        // R8 gate off, nine-bit ninth 0 accepted
        wr_ctrl(8'h90);
        rx_frame(8'h99, 1'b1, 1'b0, 1'b1);
        rd_reg(1'b0, v); chk("R8 nine gate off", {24'd0, v}, 32'hD1);
        rd_reg(1'b1, v); chk("R8 nine gate off rbuf", {24'd0, v}, 32'h99);

        // R9 reception disabled
        wr_ctrl(8'h00);
        rx_frame(8'h0F, 1'b0, 1'b0, 1'b1);
        rd_reg(1'b0, v); chk("R9 ren off ctrl", {24'd0, v}, 32'h40);
        rd_reg(1'b1, v); chk("R9 ren off rbuf", {24'd0, v}, 32'h99);
        chk("R9 irq", {31'd0, irq}, 32'd0);

        // R10 false start then a good frame
        wr_ctrl(8'h10);
        @(negedge clk); #1;
        rxd = 1'b0;
        repeat (5 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        rd_reg(1'b0, v); chk("R10 glitch no ri", {24'd0, v}, 32'h50);
        rd_reg(1'b1, v); chk("R10 glitch rbuf", {24'd0, v}, 32'h99);
        rx_frame(8'h5E, 1'b0, 1'b0, 1'b1);
        rd_reg(1'b0, v); chk("R10 recovers ri", {24'd0, v}, 32'h55);
        rd_reg(1'b1, v); chk("R10 recovers rbuf", {24'd0, v}, 32'h5E);

        mon_on = 1'b0;
        summary();
        $finish;
    end

endmodule